// File: doc/BRIEF.md
# Reserved Group-Address Trap Classifier

This block sits in the forwarding path of a multi-port switch that has one management (CPU) port. For each frame it receives the parsed destination address, an EAPOL flag from the parser, the tagged/untagged flag, the ingress port, the ingress port's spanning-tree state, whether that port has a valid default VLAN, and the port mask produced by the normal address lookup. It returns a final destination port mask, an egress tag mode and a drop flag.

Destinations in the reserved bridge group block 01-80-C2-00-00-xx are sorted into classes. Each class has its own programmable entry, which holds three things:
- a port-forward mode;
- an egress tag mode;
- a flag that makes the frame count as a bridge protocol frame, so that it passes a port whose spanning-tree state would otherwise discard it.

Software programs the entries through a write-only bank of four 32-bit words. Each word holds two entries.

The decision is registered. It appears one clock after the input strobe and holds until the next strobe.

Top module: `rsvd_mc_trap`

## Requirements
- R1: A frame whose parser EAPOL flag is clear and whose destination is 01-80-C2-00-00-00, -01, -02, -03 or -0E selects its own dedicated class entry. The entry for -00 is the bridge protocol entry.
- R2: Control word layout. The upper entry of a word uses bit 25 for the bypass flag, bits 24:22 for the tag mode and bits 18:16 for the forward mode. The lower entry uses bits 9, 8:6 and 2:0 for the same roles. The words are assigned as follows:
  - word 0: upper = EAPOL, lower = bridge protocol (-00);
  - word 1: upper = -02, lower = -01;
  - word 2: upper = -0E, lower = -03;
  - word 3: lower = catch-all; its upper half is ignored.
  A write to one word leaves the other words unchanged.
- R3: Forward mode encoding:
  - 0: the lookup mask;
  - 4: the lookup mask without the CPU port;
  - 5: the lookup mask plus the CPU port;
  - 6: the CPU port only;
  - 7: an empty mask with drop set;
  - any other value behaves as 0.
- R4: The catch-all class covers destinations -04 through -0D, -0F and -22 through -FF. Destinations -10 through -21, and all addresses outside the reserved block, match no class and use the lookup mask.
- R5: The spanning-tree state is encoded 2 = forwarding. Any other value discards, and a discarded frame has drop set. A frame whose matched class has the bypass flag set is not dropped by this rule.
- R6: An untagged frame on a port whose default-VLAN-valid flag is clear is dropped even when it matches a class with the bypass flag set. A tagged frame is not affected by this rule.
- R7: The ingress port is always removed from the output mask. Whenever drop is set, the mask is all zeros.
- R8: The egress tag mode output is the matched class's tag field. It is 0 when no class matches.
- R9: Outputs update one clock after a cycle with the input strobe high, and hold their values otherwise. A control write affects frames presented in later cycles.
- R10: After reset the outputs are zero and every entry is zero, so every class follows the lookup mask with its bypass flag clear.
- R11: A frame with the EAPOL flag set selects the EAPOL entry, whatever its destination address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_addr | input | 2 | Control word index |
| cfg_wdata | input | 32 | Control word write data |
| in_valid | input | 1 | Frame descriptor strobe |
| in_da | input | 48 | Destination MAC address |
| in_eapol | input | 1 | Parser flagged an EAPOL frame |
| in_tagged | input | 1 | Frame carries a VLAN tag |
| in_port | input | 3 | Ingress port number |
| in_stp | input | 2 | Ingress port spanning-tree state |
| in_pvid_ok | input | 1 | Ingress port has a valid default VLAN |
| in_lookup | input | 7 | Port mask from the normal lookup |
| out_valid | output | 1 | Decision strobe |
| out_mask | output | 7 | Final destination port mask |
| out_egtag | output | 3 | Egress tag mode of the matched class |
| out_drop | output | 1 | Frame is dropped |

## Verification
A corrupted entry in the control bank, or a wrong class decode, shows up in the first decision after the affected frame is presented. The mask, the tag mode or the drop flag then differs from the value computed by hand from the programmed word.

Each class is therefore given a distinct forward mode and tag mode, so that a swapped word half or a swapped class appears as a wrong mask or tag one cycle later. Discarding-state and missing-VLAN cases are run against classes with and without the bypass flag. A bypass flag read from the wrong bit turns a trapped frame into a drop on the very next output.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  // One class entry as held in the control bank
  typedef struct packed {
    logic       bypass_stp;
    logic [2:0] egtag;
    logic [2:0] fwd;
  } trap_ent_t;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_PAE  = 3'd1,
    CLS_BPDU = 3'd2,
    CLS_R01  = 3'd3,
    CLS_R02  = 3'd4,
    CLS_R03  = 3'd5,
    CLS_R0E  = 3'd6,
    CLS_REST = 3'd7
  } trap_cls_t;

  localparam int NUM_CLS  = 8;
  localparam int NUM_WORD = 4;
  localparam int ADDR_W   = $clog2(NUM_WORD);

  // Bit offsets of the two entries inside a control word
  localparam int HI_BASE  = 16;
  localparam int LO_BASE  = 0;
  localparam int FWD_OFS  = 0;
  localparam int TAG_OFS  = 6;
  localparam int BYP_OFS  = 9;

  localparam logic [2:0] FWD_LOOKUP   = 3'd0;
  localparam logic [2:0] FWD_NO_CPU   = 3'd4;
  localparam logic [2:0] FWD_ADD_CPU  = 3'd5;
  localparam logic [2:0] FWD_CPU_ONLY = 3'd6;
  localparam logic [2:0] FWD_DROP     = 3'd7;

  localparam logic [1:0] STP_FWD = 2'd2;

  localparam logic [39:0] RSVD_PREFIX = 40'h01_80_C2_00_00;

  function automatic trap_ent_t slice_ent(input logic [31:0] w, input int base);
    trap_ent_t e;
    e.bypass_stp = w[base + BYP_OFS];
    e.egtag      = w[base + TAG_OFS +: 3];
    e.fwd        = w[base + FWD_OFS +: 3];
    return e;
  endfunction

endpackage

// File: rtl/rmt_cfg_bank.sv
module rmt_cfg_bank
  import rmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output trap_ent_t         ent_o [NUM_CLS]
);

  trap_ent_t hi_q [NUM_WORD];
  trap_ent_t lo_q [NUM_WORD];
  trap_ent_t hi_d [NUM_WORD];
  trap_ent_t lo_d [NUM_WORD];
  logic [NUM_WORD-1:0] wr_en;

  for (genvar g = 0; g < NUM_WORD; g++) begin : g_word
    // next-state
    always_comb begin
      wr_en[g] = cfg_we && (cfg_addr == ADDR_W'(g));
      hi_d[g]  = slice_ent(cfg_wdata, HI_BASE);
      lo_d[g]  = slice_ent(cfg_wdata, LO_BASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '0;
      end else if (wr_en[g]) begin
        lo_q[g] <= lo_d[g];
      end
    end

    if (g == NUM_WORD - 1) begin : g_no_hi
      // the catch-all word keeps only its lower entry
      always_comb hi_q[g] = '0;
    end else begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q[g] <= '0;
        end else if (wr_en[g]) begin
          hi_q[g] <= hi_d[g];
        end
      end
    end
  end

  // Class to word-half mapping
  always_comb begin
    ent_o[CLS_NONE] = '0;
    ent_o[CLS_PAE]  = hi_q[0];
    ent_o[CLS_BPDU] = lo_q[0];
    ent_o[CLS_R02]  = hi_q[1];
    ent_o[CLS_R01]  = lo_q[1];
    ent_o[CLS_R0E]  = hi_q[2];
    ent_o[CLS_R03]  = lo_q[2];
    ent_o[CLS_REST] = lo_q[3];
  end

endmodule

// File: rtl/rmt_classify.sv
module rmt_classify
  import rmt_pkg::*;
(
  input  logic [47:0] da,
  input  logic        eapol,
  output trap_cls_t   cls
);

  logic [7:0] lo;
  logic       in_block;
  logic       rest_hit;

  always_comb begin
    lo       = da[7:0];
    in_block = (da[47:8] == RSVD_PREFIX);
    rest_hit = (lo == 8'h0F) || ((lo >= 8'h04) && (lo <= 8'h0D)) || (lo >= 8'h22);
    cls      = CLS_NONE;
    if (eapol) begin
      cls = CLS_PAE;
    end else if (in_block) begin
      case (lo)
        8'h00:   cls = CLS_BPDU;
        8'h01:   cls = CLS_R01;
        8'h02:   cls = CLS_R02;
        8'h03:   cls = CLS_R03;
        8'h0E:   cls = CLS_R0E;
        default: cls = rest_hit ? CLS_REST : CLS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rmt_decide.sv
module rmt_decide
  import rmt_pkg::*;
#(
  parameter int NPORT    = 7,
  parameter int CPU_PORT = 6,
  localparam int PW      = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             matched,
  input  trap_ent_t        ent,
  input  logic             in_tagged,
  input  logic [PW-1:0]    in_port,
  input  logic [1:0]       in_stp,
  input  logic             in_pvid_ok,
  input  logic [NPORT-1:0] in_lookup,
  output logic             out_valid,
  output logic [NPORT-1:0] out_mask,
  output logic [2:0]       out_egtag,
  output logic             out_drop
);

  localparam logic [NPORT-1:0] CPU_BIT = NPORT'(1) << CPU_PORT;

  logic [2:0]       mode;
  logic [NPORT-1:0] sel_mask, in_bit, mask_d;
  logic             mode_drop, stp_drop, vlan_drop, drop_d;
  logic [2:0]       tag_d;

  // next-state
  always_comb begin
    in_bit    = NPORT'(1) << in_port;
    mode      = matched ? ent.fwd : FWD_LOOKUP;
    mode_drop = 1'b0;
    case (mode)
      FWD_NO_CPU:   sel_mask = in_lookup & ~CPU_BIT;
      FWD_ADD_CPU:  sel_mask = in_lookup | CPU_BIT;
      FWD_CPU_ONLY: sel_mask = CPU_BIT;
      FWD_DROP: begin
        sel_mask  = '0;
        mode_drop = 1'b1;
      end
      default:      sel_mask = in_lookup;
    endcase
    stp_drop  = (in_stp != STP_FWD) && !(matched && ent.bypass_stp);
    vlan_drop = !in_tagged && !in_pvid_ok;
    drop_d    = mode_drop || stp_drop || vlan_drop;
    mask_d    = drop_d ? '0 : (sel_mask & ~in_bit);
    tag_d     = matched ? ent.egtag : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mask  <= '0;
      out_egtag <= '0;
      out_drop  <= 1'b0;
    end else if (in_valid) begin
      out_mask  <= mask_d;
      out_egtag <= tag_d;
      out_drop  <= drop_d;
    end
  end

endmodule

// File: rtl/rsvd_mc_trap.sv
module rsvd_mc_trap
  import rmt_pkg::*;
#(
  parameter int NPORT    = 7,
  parameter int CPU_PORT = 6,
  localparam int PW      = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_valid,
  input  logic [47:0]      in_da,
  input  logic             in_eapol,
  input  logic             in_tagged,
  input  logic [PW-1:0]    in_port,
  input  logic [1:0]       in_stp,
  input  logic             in_pvid_ok,
  input  logic [NPORT-1:0] in_lookup,
  output logic             out_valid,
  output logic [NPORT-1:0] out_mask,
  output logic [2:0]       out_egtag,
  output logic             out_drop
);

  trap_ent_t ent_tab [NUM_CLS];
  trap_cls_t cls;
  trap_ent_t sel_ent;
  logic      matched;

  rmt_cfg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ent_o     (ent_tab)
  );

  rmt_classify u_cls (
    .da    (in_da),
    .eapol (in_eapol),
    .cls   (cls)
  );

  always_comb begin
    sel_ent = ent_tab[cls];
    matched = (cls != CLS_NONE);
  end

  rmt_decide #(.NPORT(NPORT), .CPU_PORT(CPU_PORT)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .matched    (matched),
    .ent        (sel_ent),
    .in_tagged  (in_tagged),
    .in_port    (in_port),
    .in_stp     (in_stp),
    .in_pvid_ok (in_pvid_ok),
    .in_lookup  (in_lookup),
    .out_valid  (out_valid),
    .out_mask   (out_mask),
    .out_egtag  (out_egtag),
    .out_drop   (out_drop)
  );

endmodule

// File: rtl/rmt_chk.sv
module rmt_chk
  import rmt_pkg::*;
#(
  parameter int NPORT = 7,
  parameter int PW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [47:0]      in_da,
  input logic             in_eapol,
  input logic             in_tagged,
  input logic [PW-1:0]    in_port,
  input logic [1:0]       in_stp,
  input logic             in_pvid_ok,
  input logic             out_valid,
  input logic [NPORT-1:0] out_mask,
  input logic             out_drop
);

  // R9
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_mask) && $stable(out_drop));

  // R7
  drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop) |-> (out_mask == '0));

  // R7
  no_hairpin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_mask[$past(in_port)] == 1'b0));

  // R6
  vlan_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_tagged && !in_pvid_ok) |=> out_drop);

  // R5
  stp_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_eapol && (in_da[47:8] != RSVD_PREFIX) && (in_stp != STP_FWD))
      |=> out_drop);

endmodule

bind rsvd_mc_trap rmt_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_da      (in_da),
  .in_eapol   (in_eapol),
  .in_tagged  (in_tagged),
  .in_port    (in_port),
  .in_stp     (in_stp),
  .in_pvid_ok (in_pvid_ok),
  .out_valid  (out_valid),
  .out_mask   (out_mask),
  .out_drop   (out_drop)
);

// File: tb/sim_rsvd_mc_trap.sv
`timescale 1ns/1ps
module sim_rsvd_mc_trap;
  localparam int NPORT = 7;
  localparam int PW    = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_addr;
  logic [31:0]      cfg_wdata;
  logic             in_valid;
  logic [47:0]      in_da;
  logic             in_eapol;
  logic             in_tagged;
  logic [PW-1:0]    in_port;
  logic [1:0]       in_stp;
  logic             in_pvid_ok;
  logic [NPORT-1:0] in_lookup;
  logic             out_valid;
  logic [NPORT-1:0] out_mask;
  logic [2:0]       out_egtag;
  logic             out_drop;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rsvd_mc_trap u0 (.*);

  localparam logic [1:0] DISC = 2'd0;
  localparam logic [1:0] FWD  = 2'd2;

  function automatic logic [47:0] rda(input logic [7:0] lo);
    return {40'h01_80_C2_00_00, lo};
  endfunction

  function automatic logic [9:0] ent(input bit byp, input logic [2:0] tag, input logic [2:0] fwd);
    return {byp, tag, 3'b000, fwd};
  endfunction

  function automatic logic [31:0] word(input logic [9:0] hi, input logic [9:0] lo);
    return {6'b0, hi, 6'b0, lo};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame(input logic [47:0] da, input bit eap, input bit tg, input int port,
                       input logic [1:0] stp, input bit pv, input logic [NPORT-1:0] lk);
    @(negedge clk);
    in_da = da; in_eapol = eap; in_tagged = tg; in_port = PW'(port);
    in_stp = stp; in_pvid_ok = pv; in_lookup = lk; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [NPORT-1:0] m, input bit d, input logic [2:0] t);
    chk(req, "valid", 32'(out_valid), 32'd1);
    chk(req, "mask",  32'(out_mask),  32'(m));
    chk(req, "drop",  32'(out_drop),  32'(d));
    chk(req, "tag",   32'(out_egtag), 32'(t));
  endtask

  task automatic t_reset;
    // R10 outputs cleared
    chk("R10", "valid", 32'(out_valid), 0);
    chk("R10", "mask",  32'(out_mask),  0);
    chk("R10", "drop",  32'(out_drop),  0);
    chk("R10", "tag",   32'(out_egtag), 0);
  endtask

  task automatic t_defaults;
    // R10 default entries follow the lookup mask
    frame(rda(8'h00), 0, 1, 0, FWD, 1, 7'h0F);
    expect_out("R10", 7'h0E, 0, 0);
    // R9 outputs hold with no strobe
    @(negedge clk);
    chk("R9", "valid idle", 32'(out_valid), 0);
    chk("R9", "mask hold",  32'(out_mask),  32'h0E);
    // R5 bypass clear by default, so a discarding port drops
    frame(rda(8'h00), 0, 1, 0, DISC, 1, 7'h0F);
    expect_out("R5", 7'h00, 1, 0);
  endtask

  task automatic t_word0;
    cfg(2'd0, word(ent(0, 3'd0, 3'd5), ent(1, 3'd1, 3'd6)));
    // R2 R3 R5 R8 bridge protocol entry: CPU only, bypass, untagged mode 1
    frame(rda(8'h00), 0, 1, 1, DISC, 1, 7'h0C);
    expect_out("R2", 7'h40, 0, 1);
    // R11 EAPOL beats the -03 address; R3 mode 5 adds CPU
    frame(rda(8'h03), 1, 1, 0, FWD, 1, 7'h05);
    expect_out("R11", 7'h44, 0, 0);
    // R5 EAPOL entry has no bypass
    frame(rda(8'h03), 1, 1, 0, DISC, 1, 7'h05);
    expect_out("R5", 7'h00, 1, 0);
  endtask

  task automatic t_word1;
    cfg(2'd1, word(ent(0, 3'd2, 3'd4), ent(0, 3'd0, 3'd7)));
    // R3 mode 7 drops
    frame(rda(8'h01), 0, 1, 0, FWD, 1, 7'h7F);
    expect_out("R3", 7'h00, 1, 0);
    // R3 mode 4 removes CPU; R8 tag of the -02 entry
    frame(rda(8'h02), 0, 1, 0, FWD, 1, 7'h43);
    expect_out("R8", 7'h02, 0, 2);
  endtask

  task automatic t_word2;
    cfg(2'd2, word(ent(0, 3'd0, 3'd3), ent(1, 3'd3, 3'd6)));
    // R3 unlisted mode 3 behaves as follow lookup
    frame(rda(8'h0E), 0, 1, 4, FWD, 1, 7'h30);
    expect_out("R3", 7'h20, 0, 0);
    // R1 -03 entry traps with bypass
    frame(rda(8'h03), 0, 1, 2, DISC, 1, 7'h01);
    expect_out("R1", 7'h40, 0, 3);
    // R2 writing word 2 left word 0 intact
    frame(rda(8'h00), 0, 1, 1, DISC, 1, 7'h0C);
    expect_out("R2", 7'h40, 0, 1);
  endtask

  task automatic t_rest;
    // upper half of word 3 must be ignored
    cfg(2'd3, word(ent(1, 3'd7, 3'd7), ent(1, 3'd1, 3'd6)));
    foreach (rest_set[i]) begin
      frame(rda(rest_set[i]), 0, 1, 0, DISC, 1, 7'h11);
      expect_out("R4", 7'h40, 0, 1);
    end
    // R4 -10 and -21 match nothing
    frame(rda(8'h10), 0, 1, 0, FWD, 1, 7'h11);
    expect_out("R4", 7'h10, 0, 0);
    frame(rda(8'h21), 0, 1, 0, DISC, 1, 7'h11);
    expect_out("R4", 7'h00, 1, 0);
    // R4 address outside the block
    frame(48'h01_80_C2_00_01_00, 0, 1, 0, FWD, 1, 7'h11);
    expect_out("R4", 7'h10, 0, 0);
  endtask

  logic [7:0] rest_set [6] = '{8'h04, 8'h0D, 8'h0F, 8'h22, 8'h80, 8'hFF};

  task automatic t_vlan;
    // R6 untagged and no default VLAN: dropped despite bypass
    frame(rda(8'h00), 0, 0, 1, DISC, 0, 7'h0C);
    expect_out("R6", 7'h00, 1, 1);
    frame(rda(8'h00), 0, 0, 1, DISC, 1, 7'h0C);
    expect_out("R6", 7'h40, 0, 1);
    frame(rda(8'h00), 0, 1, 1, FWD, 0, 7'h0C);
    expect_out("R6", 7'h40, 0, 1);
  endtask

  task automatic t_ingress;
    // R7 CPU as ingress with CPU-only mode
    frame(rda(8'h00), 0, 1, 6, FWD, 1, 7'h01);
    expect_out("R7", 7'h00, 0, 1);
    // R7 mode 4 on port 3: CPU and port 3 removed
    frame(rda(8'h02), 0, 1, 3, FWD, 1, 7'h7F);
    expect_out("R7", 7'h37, 0, 2);
  endtask

  task automatic t_rewrite;
    // R9 rewrite takes effect on the next frame
    cfg(2'd0, 32'h0);
    frame(rda(8'h00), 0, 1, 0, FWD, 1, 7'h0F);
    expect_out("R9", 7'h0E, 0, 0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_da = '0; in_eapol = 1'b0; in_tagged = 1'b0;
    in_port = '0; in_stp = FWD; in_pvid_ok = 1'b1; in_lookup = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_word0();
    t_word1();
    t_word2();
    t_rest();
    t_vlan();
    t_ingress();
    t_rewrite();
    finish_run();
  end

endmodule